// File: doc/BRIEF.md
# Sample-to-Memory-Word Packer and Unpacker

The block gathers a stream of fixed-width video samples into 256-bit words for burst writes to external memory. On the read side it splits such words back into samples. A mode input selects how samples are laid out. In pixel mode each sample is a 20-bit 4:2:2 luma/chroma pair. In motion mode each sample is a 10-bit motion value. Each word holds only whole samples, so a sample never crosses a word boundary. The bits left over above the last whole sample are always zero.

The packer has a valid/ready sample input and a valid/ready word output. Next to each word it reports how many sample slots carry data, and whether the word closes a frame. An end-of-frame flag on the sample input sends out a partly filled word early, with its empty slots zeroed. The unpacker takes words with the same count and frame flag and emits their samples in packing order. It skips the empty slots and the zero tail. The mode must be held constant while either path holds a partial word.

Top module: `sample_word_packer`

## Requirements
- R1: With mode_motion low, a full word holds 12 samples. Sample k sits at bits [20k+19:20k], and w_count is 12.
- R2: With mode_motion high, a full word holds 25 samples, using only bits [9:0] of s_data. Sample k sits at bits [10k+9:10k], and w_count is 25.
- R3: Every bit of w_data that carries no sample is zero. In pixel mode this includes bits [255:240]; in motion mode it includes bits [255:250]. It also includes the unused slots of a partial word.
- R4: A sample accepted with s_last high closes the word at once. w_count then equals the number of samples in that word, and w_last is high. A word closed only because it is full has w_last low.
- R5: While w_valid is high and w_ready is low, w_data, w_count and w_last hold their values and no sample is accepted. No sample is lost or duplicated under any pattern of stalls.
- R6: After reset, w_valid and u_valid are low, and s_ready and r_ready are high.
- R7: The unpacker emits samples 0 to n-1 of each word in order, where n is r_count. Each sample comes from the slot that R1 or R2 gives for it. In motion mode u_data is zero above bit 9.
- R8: u_last is high only on the final sample of a word that arrived with r_last high.
- R9: A word with r_count of zero is consumed with no sample emitted. A count above the mode's per-word limit (12 or 25) is treated as that limit.
- R10: While u_valid is high and u_ready is low, u_data and u_last hold their values.
- R11: A packed stream fed back through the unpacker reproduces the original sample sequence and its frame end. This holds in both modes, for any frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_motion | input | 1 | 0 = 20-bit pixel samples, 1 = 10-bit motion samples |
| s_valid | input | 1 | Sample input valid |
| s_ready | output | 1 | Sample input ready |
| s_data | input | 20 | Sample value (bits [9:0] in motion mode) |
| s_last | input | 1 | Sample ends the frame |
| w_valid | output | 1 | Packed word valid |
| w_ready | input | 1 | Packed word accepted |
| w_data | output | 256 | Packed word |
| w_count | output | 5 | Number of filled sample slots |
| w_last | output | 1 | Word ends the frame |
| r_valid | input | 1 | Word to unpack valid |
| r_ready | output | 1 | Word to unpack accepted |
| r_data | input | 256 | Word to unpack |
| r_count | input | 5 | Filled sample slots in r_data |
| r_last | input | 1 | Word ends a frame |
| u_valid | output | 1 | Unpacked sample valid |
| u_ready | input | 1 | Unpacked sample accepted |
| u_data | output | 20 | Unpacked sample |
| u_last | output | 1 | Final sample of a frame |

## Verification
Two events can fall in the same clock cycle on each path. In the packer, a sample that closes a word can arrive in the same cycle the previous word is accepted downstream. In the unpacker, a new word can be loaded in the same cycle its final sample is accepted. The bench provokes both by looping the word output straight into the unpacker, with random valid gaps and random ready stalls on both ends. It also uses frame lengths that end exactly on a word boundary, one sample past it, and one sample short of it. Each word is compared with a layout built by a bench function, each stall is checked for a held word, and the unpacked stream must equal the original sample by sample, including where the frame ends.

// File: rtl/sample_word_packer.sv
module sample_word_packer #(
  parameter int WORD_W = 256,
  parameter int PIX_W  = 20,
  parameter int MOT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_motion,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic              s_last,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [WORD_W-1:0] w_data,
  output logic [$clog2(WORD_W/MOT_W+1)-1:0] w_count,
  output logic              w_last,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [WORD_W-1:0] r_data,
  input  logic [$clog2(WORD_W/MOT_W+1)-1:0] r_count,
  input  logic              r_last,
  output logic              u_valid,
  input  logic              u_ready,
  output logic [PIX_W-1:0]  u_data,
  output logic              u_last
);

  localparam int PIX_N = WORD_W / PIX_W;
  localparam int MOT_N = WORD_W / MOT_W;
  localparam int CNT_W = $clog2(MOT_N + 1);
  localparam int SH_W  = $clog2(WORD_W);

  logic [CNT_W-1:0] per_word;
  assign per_word = mode_motion ? CNT_W'(MOT_N) : CNT_W'(PIX_N);

  // packer
  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  fill;
  logic [PIX_W-1:0]  s_samp;
  logic [SH_W-1:0]   ppos;
  logic [WORD_W-1:0] placed;
  logic              take, close;

  assign s_samp = mode_motion ? {{(PIX_W-MOT_W){1'b0}}, s_data[MOT_W-1:0]} : s_data;
  assign ppos   = mode_motion ? SH_W'(fill) * SH_W'(MOT_W) : SH_W'(fill) * SH_W'(PIX_W);
  assign placed = {{(WORD_W-PIX_W){1'b0}}, s_samp} << ppos;
  assign s_ready = !w_valid || w_ready;
  assign take    = s_valid && s_ready;
  assign close   = take && (s_last || fill == per_word - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      fill    <= '0;
      w_valid <= 1'b0;
      w_data  <= '0;
      w_count <= '0;
      w_last  <= 1'b0;
    end else begin
      if (w_valid && w_ready) w_valid <= 1'b0;
      if (take) begin
        if (close) begin
          w_data  <= acc | placed;
          w_count <= fill + CNT_W'(1);
          w_last  <= s_last;
          w_valid <= 1'b1;
          acc     <= '0;
          fill    <= '0;
        end else begin
          acc  <= acc | placed;
          fill <= fill + CNT_W'(1);
        end
      end
    end
  end

  // R5
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_count) && $stable(w_last));
  // R3
  pix_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !mode_motion |-> w_data[WORD_W-1:PIX_N*PIX_W] == '0);
  // R3
  mot_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && mode_motion |-> w_data[WORD_W-1:MOT_N*MOT_W] == '0);
  // R4
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> w_count != '0 && w_count <= per_word && (w_last || w_count == per_word));

  // unpacker
  logic [WORD_W-1:0] hold;
  logic [CNT_W-1:0]  idx, lim, r_lim;
  logic              busy, hold_last, last_out;
  logic [SH_W-1:0]   upos;
  logic [WORD_W-1:0] shifted;

  assign r_lim    = (r_count > per_word) ? per_word : r_count;
  assign last_out = busy && idx == lim - CNT_W'(1);
  assign r_ready  = !busy || (u_ready && last_out);
  assign u_valid  = busy;
  assign upos     = mode_motion ? SH_W'(idx) * SH_W'(MOT_W) : SH_W'(idx) * SH_W'(PIX_W);
  assign shifted  = hold >> upos;
  assign u_data   = mode_motion ? {{(PIX_W-MOT_W){1'b0}}, shifted[MOT_W-1:0]} : shifted[PIX_W-1:0];
  assign u_last   = last_out && hold_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      idx       <= '0;
      lim       <= '0;
      busy      <= 1'b0;
      hold_last <= 1'b0;
    end else begin
      if (u_valid && u_ready) begin
        idx <= idx + CNT_W'(1);
        if (last_out) busy <= 1'b0;
      end
      if (r_valid && r_ready) begin
        hold      <= r_data;
        lim       <= r_lim;
        hold_last <= r_last;
        idx       <= '0;
        busy      <= r_lim != '0;
      end
    end
  end

  // R10
  u_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid && !u_ready |=> u_valid && $stable(u_data) && $stable(u_last));
  // R7
  u_motion_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid && mode_motion |-> u_data[PIX_W-1:MOT_W] == '0);

endmodule

// File: tb/sample_word_packer_test.sv
module sample_word_packer_test;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic mode = 0, s_valid = 0, s_last = 0, tb_wready = 0, tb_rvalid = 0, tb_rlast = 0, u_ready = 0, lbk = 0;
  logic [19:0] s_data = '0;
  logic [255:0] tb_rdata = '0;
  logic [4:0] tb_rcount = '0;
  logic s_ready, w_valid, w_last, r_ready, u_valid, u_last;
  logic [255:0] w_data;
  logic [4:0] w_count;
  logic [19:0] u_data;
  logic w_ready_i, r_valid_i, r_last_i;
  logic [255:0] r_data_i;
  logic [4:0] r_count_i;

  assign w_ready_i = lbk ? r_ready : tb_wready;
  assign r_valid_i = lbk ? w_valid : tb_rvalid;
  assign r_data_i  = lbk ? w_data  : tb_rdata;
  assign r_count_i = lbk ? w_count : tb_rcount;
  assign r_last_i  = lbk ? w_last  : tb_rlast;

  sample_word_packer uut (
    .clk(clk), .rst_n(rst_n), .mode_motion(mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .w_valid(w_valid), .w_ready(w_ready_i), .w_data(w_data), .w_count(w_count), .w_last(w_last),
    .r_valid(r_valid_i), .r_ready(r_ready), .r_data(r_data_i), .r_count(r_count_i), .r_last(r_last_i),
    .u_valid(u_valid), .u_ready(u_ready), .u_data(u_data), .u_last(u_last));

  int checks = 0, failures = 0, cycles = 0;
  logic [19:0] smp [0:299];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] msk(input bit md, input logic [19:0] v);
    return md ? {10'b0, v[9:0]} : v;
  endfunction

  function automatic logic [255:0] exp_word(input bit md, input int base, input int cnt);
    logic [255:0] w = '0;
    for (int k = 0; k < cnt; k++)
      w |= {236'b0, msk(md, smp[base+k])} << (k * (md ? 10 : 20));
    return w;
  endfunction

  task automatic run_frame(input bit md, input int n, input bit lb, input int bp);
    int sent = 0, wdone = 0, got = 0, cyc = 0, per, cnt;
    bit prev_stall = 0;
    logic [255:0] prev_w = '0;
    per = md ? 25 : 12;
    mode = md; lbk = lb;
    for (int i = 0; i < n; i++) smp[i] = 20'($urandom);
    while ((lb ? got < n : wdone < n) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      s_valid = (sent < n) && ($urandom % 4 != 0);
      s_data  = (sent < n) ? smp[sent] : 20'($urandom);
      s_last  = (sent == n - 1);
      tb_wready = ($urandom % 100) >= bp;
      u_ready   = ($urandom % 100) >= bp;
      #1;
      if (prev_stall) chk(w_valid && w_data == prev_w, "R5 stalled word held", w_data, prev_w);
      if (s_valid && s_ready) sent++;
      if (w_valid && w_ready_i) begin
        cnt = (n - wdone < per) ? n - wdone : per;
        chk(w_data == exp_word(md, wdone, cnt), md ? "R2/R3 motion word" : "R1/R3 pixel word",
            w_data, exp_word(md, wdone, cnt));
        chk(w_count == 5'(cnt), "R4 word count", 256'(w_count), 256'(cnt));
        chk(w_last == (wdone + cnt == n), "R4 frame end flag", 256'(w_last), 256'(wdone + cnt == n));
        wdone += cnt;
      end
      if (u_valid && u_ready) begin
        chk(got < n && u_data == msk(md, smp[got]), "R11 loopback sample", 256'(u_data), 256'(msk(md, smp[got])));
        chk(u_last == (got == n - 1), "R8 loopback last", 256'(u_last), 256'(got == n - 1));
        got++;
      end
      prev_stall = w_valid && !w_ready_i;
      prev_w = w_data;
    end
    chk(lb ? got == n : wdone == n, "R11 frame completes", 256'(lb ? got : wdone), 256'(n));
    @(negedge clk);
    s_valid = 0; s_last = 0; u_ready = 0; tb_wready = 0;
    @(negedge clk);
  endtask

  task automatic unpack_one(input bit md, input logic [255:0] d, input int cnt, input bit lst);
    int e, per, w;
    per = md ? 25 : 12;
    w = md ? 10 : 20;
    e = (cnt > per) ? per : cnt;
    lbk = 0; mode = md; s_valid = 0;
    @(negedge clk);
    tb_rvalid = 1; tb_rdata = d; tb_rcount = 5'(cnt); tb_rlast = lst; u_ready = 1;
    #1;
    chk(r_ready, "R9 unpacker idle ready", 256'(r_ready), 256'(1));
    @(negedge clk);
    tb_rvalid = 0;
    for (int k = 0; k < e; k++) begin
      logic [19:0] ex;
      #1;
      ex = msk(md, 20'(d >> (k * w)));
      chk(u_valid && u_data == ex, "R7 unpacked slot", 256'(u_data), 256'(ex));
      chk(u_last == (lst && k == e - 1), "R8 unpack last", 256'(u_last), 256'(lst && k == e - 1));
      @(negedge clk);
    end
    #1;
    chk(!u_valid, "R9 sample count limit", 256'(u_valid), 256'(0));
    u_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!w_valid && !u_valid && s_ready && r_ready, "R6 reset state",
        256'({w_valid, u_valid, s_ready, r_ready}), 256'(4'b0011));
    // directed boundaries: exact word, one past, one short, single sample
    run_frame(0, 12, 0, 0);
    run_frame(1, 25, 0, 0);
    run_frame(0, 13, 1, 0);
    run_frame(1, 24, 1, 30);
    run_frame(0, 1, 1, 0);
    run_frame(1, 26, 1, 50);
    run_frame(0, 36, 0, 60);
    run_frame(1, 50, 1, 0);
    // unpacker corner cases
    unpack_one(0, {8{32'hA5C3_1E7F}}, 12, 1);
    unpack_one(1, {8{$urandom}}, 25, 0);
    unpack_one(1, {8{$urandom}}, 7, 1);
    unpack_one(0, {8{$urandom}}, 0, 1);
    unpack_one(0, {8{$urandom}}, 20, 1);
    unpack_one(1, {8{$urandom}}, 31, 1);
    // random frames
    for (int t = 0; t < 40; t++)
      run_frame(1'($urandom % 2), 1 + int'($urandom % 90), 1'($urandom % 2), int'($urandom % 70));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule